// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block is the multi-cycle sequencer of an 8-bit processor core that runs every operation touching the hardware stack. It performs the reset sequence, hardware interrupt entry (non-maskable and maskable), the software break, subroutine call and return, interrupt return, and the four single-byte stack operations. It owns the 8-bit stack pointer. It reads the program counter, the status register and the accumulator from the core, and hands updated values back through write strobes. Memory is reached over a one-access-per-cycle bus. Read data is taken in the same cycle the address is presented.

The core presents a request and holds it until the sequencer pulses `done`. A request is judged once, in the cycle it is accepted. A reset request always runs. Otherwise a pending non-maskable interrupt is taken first, and then a pending maskable interrupt if the interrupt-disable flag is clear. Either of these replaces the presented request, and `done_kind` tells the core which sequence actually ran. The core then re-presents its request.

Top module: `stack_seq`

## Requirements
- R1: A push writes `bus_wdata` to address 0x0100 + SP with `bus_we` high, and SP becomes SP-1 (8-bit wrap, so a push at SP=0x00 leaves SP=0xFF). No write ever leaves page 0x01.
- R2: Every pull begins with one dummy cycle at 0x0100 + SP. It then increments SP and reads at the new 0x0100 + SP. A pull at SP=0xFF reads address 0x0100 and leaves SP=0x00.
- R3: Interrupt entry (NMI, IRQ, break) pushes PC[15:8], then PC[7:0], then status. It then reads the vector low byte and the high byte at vector+1 into PC. It writes status with bit 2 (interrupt disable) set. It takes 5 cycles.
- R4: The vector is 0xFFFA for NMI, 0xFFFC for reset, and 0xFFFE for IRQ and break.
- R5: `req_kind` codes are 0 reset, 1 NMI, 2 IRQ, 3 break, 4 call, 5 return, 6 interrupt return, 7 stack op. The priority is: a reset request, then `nmi_pend`, then `irq_pend` with status bit 2 clear, then the requested code. A requested IRQ with bit 2 set finishes in 1 cycle with `done_kind`=2, with no bus write and no register write.
- R6: Reset writes A=0 and status=0, pulses `xy_clr` once, sets SP=0xFF and loads PC from 0xFFFC/0xFFFD. It takes 3 cycles.
- R7: Break pushes PC+1 and status OR 0x30. The new status is the old status OR 0x34.
- R8: With `req_stk` 0, the stack op pushes status OR 0x30. With `req_stk` 1, it pushes A. Each takes 1 cycle.
- R9: With `req_stk` 2, and in interrupt return, the pulled byte replaces only the status bits under mask 0xCF, so bits 4 and 5 keep their values. With `req_stk` 3, the pulled byte loads A and sets N (bit 7) and Z (bit 1) from it. Each single-byte pull takes 2 cycles.
- R10: A call makes one dummy stack read and pushes `pc_in` high then low byte. `pc_in` points at the last operand byte. The call then sets PC = {byte at `pc_in`, `req_opnd`}. It takes 4 cycles.
- R11: A subroutine return pulls PC low then high and writes PC+1 (4 cycles). An interrupt return pulls status, then PC low, then PC high, and writes PC unchanged (4 cycles).
- R12: Request, interrupt and operand inputs are ignored from acceptance until `done`. `done` is high for exactly one cycle per sequence. `done_kind` gives the code of the sequence that ran, with 7 for any stack op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer state |
| req_valid | input | 1 | Request present; held until `done` |
| req_kind | input | 3 | Requested sequence code |
| req_stk | input | 2 | Stack op selector (0 push status, 1 push A, 2 pull status, 3 pull A) |
| req_opnd | input | 8 | Call target low byte |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| irq_pend | input | 1 | Maskable interrupt pending |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status register |
| acc_in | input | 8 | Current accumulator |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_we | output | 1 | Memory write enable |
| bus_rdata | input | 8 | Memory read data, same cycle |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | Program counter write strobe |
| status_out | output | 8 | New status value |
| status_we | output | 1 | Status write strobe |
| acc_out | output | 8 | New accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| xy_clr | output | 1 | Clear index registers |
| sp_out | output | 8 | Stack pointer |
| done | output | 1 | Sequence completes this cycle |
| done_kind | output | 3 | Code of the completed sequence |

## Verification
The interesting overlap is interrupt arbitration against an ordinary request. A request can meet a pending non-maskable interrupt, a pending maskable interrupt, or both in the same acceptance cycle. Interrupt lines and request fields can also change while a sequence is running. The bench raises both interrupt lines together with stack-op, break and IRQ requests, under both settings of the interrupt-disable bit. During every running sequence it scrambles all request and interrupt inputs. Each case is judged by `done_kind`, the cycle count, and the bytes pushed and registers written, compared with the arbitration order of R5.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 16;

  localparam logic [DATA_W-1:0] PUSH_SET  = 8'h30;
  localparam logic [DATA_W-1:0] PULL_MASK = 8'hCF;
  localparam logic [DATA_W-1:0] IDIS_BIT  = 8'h04;

  typedef enum logic [2:0] {
    RQ_RESET, RQ_NMI, RQ_IRQ, RQ_BRK, RQ_CALL, RQ_RET, RQ_IRET, RQ_STK
  } req_e;

  typedef enum logic [1:0] { SK_PUSH_ST, SK_PUSH_A, SK_PULL_ST, SK_PULL_A } stk_e;

  typedef enum logic [3:0] {
    SQ_RESET, SQ_NMI, SQ_IRQ, SQ_BRK, SQ_CALL, SQ_RET, SQ_IRET,
    SQ_PUSH_ST, SQ_PUSH_A, SQ_PULL_ST, SQ_PULL_A, SQ_SKIP
  } seq_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RINIT, ST_PUSH_H, ST_PUSH_L, ST_PUSH_S, ST_VEC_L, ST_VEC_H,
    ST_DUMMY, ST_PULL_S, ST_PULL_L, ST_PULL_H, ST_PC_INC, ST_OPND_HI,
    ST_PUSH_B, ST_PULL_B, ST_SKIP
  } state_e;

  typedef enum logic [1:0] { SP_HOLD, SP_INC, SP_DEC, SP_LOAD } sp_op_e;

  // status image written to the stack by break / push-status
  function automatic logic [DATA_W-1:0] push_image(input logic [DATA_W-1:0] st);
    return st | PUSH_SET;
  endfunction

  // restore only the bits under the pull mask
  function automatic logic [DATA_W-1:0] pull_merge(input logic [DATA_W-1:0] old_st,
                                                   input logic [DATA_W-1:0] pulled);
    return (old_st & ~PULL_MASK) | (pulled & PULL_MASK);
  endfunction

  // N in bit 7, Z in bit 1
  function automatic logic [DATA_W-1:0] load_flags(input logic [DATA_W-1:0] st,
                                                   input logic [DATA_W-1:0] v);
    return {v[7], st[6:2], (v == '0), st[0]};
  endfunction

  function automatic state_e first_state(input seq_e s);
    case (s)
      SQ_RESET:                       return ST_RINIT;
      SQ_NMI, SQ_IRQ, SQ_BRK:         return ST_PUSH_H;
      SQ_PUSH_ST, SQ_PUSH_A:          return ST_PUSH_B;
      SQ_SKIP:                        return ST_SKIP;
      default:                        return ST_DUMMY;
    endcase
  endfunction

  function automatic logic [2:0] seq_code(input seq_e s);
    case (s)
      SQ_RESET: return 3'd0;
      SQ_NMI:   return 3'd1;
      SQ_IRQ, SQ_SKIP: return 3'd2;
      SQ_BRK:   return 3'd3;
      SQ_CALL:  return 3'd4;
      SQ_RET:   return 3'd5;
      SQ_IRET:  return 3'd6;
      default:  return 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/ssq_arbiter.sv
module ssq_arbiter
  import ssq_pkg::*;
(
  input  req_e       kind,
  input  stk_e       stk,
  input  logic       nmi_pend,
  input  logic       irq_pend,
  input  logic       irq_mask,
  output seq_e       seq
);
  always_comb begin
    if (kind == RQ_RESET)             seq = SQ_RESET;
    else if (nmi_pend)                seq = SQ_NMI;
    else if (irq_pend && !irq_mask)   seq = SQ_IRQ;
    else begin
      case (kind)
        RQ_NMI:  seq = SQ_NMI;
        RQ_IRQ:  seq = irq_mask ? SQ_SKIP : SQ_IRQ;
        RQ_BRK:  seq = SQ_BRK;
        RQ_CALL: seq = SQ_CALL;
        RQ_RET:  seq = SQ_RET;
        RQ_IRET: seq = SQ_IRET;
        default: begin
          case (stk)
            SK_PUSH_ST: seq = SQ_PUSH_ST;
            SK_PUSH_A:  seq = SQ_PUSH_A;
            SK_PULL_ST: seq = SQ_PULL_ST;
            default:    seq = SQ_PULL_A;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/ssq_sp_unit.sv
module ssq_sp_unit
  import ssq_pkg::*;
#(
  parameter logic [DATA_W-1:0] PAGE    = 8'h01,
  parameter logic [DATA_W-1:0] SP_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sp_op_e            op,
  output logic [DATA_W-1:0] sp,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= SP_INIT;
    else begin
      case (op)
        SP_INC:  sp <= sp + 1'b1;
        SP_DEC:  sp <= sp - 1'b1;
        SP_LOAD: sp <= SP_INIT;
        default: sp <= sp;
      endcase
    end
  end

  assign addr = {PAGE, sp};
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import ssq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [1:0]        req_stk,
  input  logic [DATA_W-1:0] req_opnd,
  input  logic              nmi_pend,
  input  logic              irq_pend,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic              pc_we,
  output logic [DATA_W-1:0] status_out,
  output logic              status_we,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_we,
  output logic              xy_clr,
  output logic [DATA_W-1:0] sp_out,
  output logic              done,
  output logic [2:0]        done_kind
);
  state_e            state_q, state_d;
  seq_e              seq_q, seq_pick;
  sp_op_e            sp_op;
  logic [ADDR_W-1:0] stk_addr;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] st_q, acc_q, opnd_q, lo_q, hi_q;
  logic              accept;

  // named internal events used by the checker
  logic              entry_commit;
  logic              vec_fetch;

  function automatic logic [ADDR_W-1:0] vec_of(input seq_e s);
    case (s)
      SQ_RESET: return VEC_RST;
      SQ_NMI:   return VEC_NMI;
      default:  return VEC_IRQ;
    endcase
  endfunction

  ssq_arbiter u_arb (
    .kind     (req_e'(req_kind)),
    .stk      (stk_e'(req_stk)),
    .nmi_pend (nmi_pend),
    .irq_pend (irq_pend),
    .irq_mask (status_in[2]),
    .seq      (seq_pick)
  );

  ssq_sp_unit #(.PAGE(STACK_PAGE), .SP_INIT(8'hFF)) u_sp (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (sp_op),
    .sp    (sp_out),
    .addr  (stk_addr)
  );

  assign accept       = (state_q == ST_IDLE) && req_valid;
  assign entry_commit = (state_q == ST_VEC_H) && (seq_q != SQ_RESET);
  assign vec_fetch    = (state_q == ST_VEC_L) || (state_q == ST_VEC_H);
  assign done_kind    = seq_code(seq_q);

  always_comb begin
    state_d    = state_q;
    sp_op      = SP_HOLD;
    bus_addr   = stk_addr;
    bus_wdata  = '0;
    bus_we     = 1'b0;
    pc_out     = {hi_q, lo_q};
    pc_we      = 1'b0;
    status_out = st_q;
    status_we  = 1'b0;
    acc_out    = '0;
    acc_we     = 1'b0;
    xy_clr     = 1'b0;
    done       = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) state_d = first_state(seq_pick);
      ST_RINIT: begin
        sp_op      = SP_LOAD;
        status_out = '0;
        status_we  = 1'b1;
        acc_we     = 1'b1;
        xy_clr     = 1'b1;
        state_d    = ST_VEC_L;
      end
      ST_PUSH_H: begin
        bus_we    = 1'b1;
        bus_wdata = pc_q[15:8];
        sp_op     = SP_DEC;
        state_d   = ST_PUSH_L;
      end
      ST_PUSH_L: begin
        bus_we    = 1'b1;
        bus_wdata = pc_q[7:0];
        sp_op     = SP_DEC;
        state_d   = (seq_q == SQ_CALL) ? ST_OPND_HI : ST_PUSH_S;
      end
      ST_PUSH_S: begin
        bus_we    = 1'b1;
        bus_wdata = st_q;
        sp_op     = SP_DEC;
        state_d   = ST_VEC_L;
      end
      ST_VEC_L: begin
        bus_addr = vec_of(seq_q);
        state_d  = ST_VEC_H;
      end
      ST_VEC_H: begin
        bus_addr   = vec_of(seq_q) + 1'b1;
        pc_out     = {bus_rdata, lo_q};
        pc_we      = 1'b1;
        status_out = st_q | IDIS_BIT;
        status_we  = (seq_q != SQ_RESET);
        done       = 1'b1;
        state_d    = ST_IDLE;
      end
      ST_DUMMY: begin
        if (seq_q == SQ_CALL) state_d = ST_PUSH_H;
        else begin
          sp_op = SP_INC;
          case (seq_q)
            SQ_IRET: state_d = ST_PULL_S;
            SQ_RET:  state_d = ST_PULL_L;
            default: state_d = ST_PULL_B;
          endcase
        end
      end
      ST_PULL_S: begin
        status_out = pull_merge(st_q, bus_rdata);
        status_we  = 1'b1;
        sp_op      = SP_INC;
        state_d    = ST_PULL_L;
      end
      ST_PULL_L: begin
        sp_op   = SP_INC;
        state_d = ST_PULL_H;
      end
      ST_PULL_H: begin
        if (seq_q == SQ_RET) state_d = ST_PC_INC;
        else begin
          pc_out  = {bus_rdata, lo_q};
          pc_we   = 1'b1;
          done    = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_PC_INC: begin
        pc_out  = {hi_q, lo_q} + 1'b1;
        pc_we   = 1'b1;
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      ST_OPND_HI: begin
        bus_addr = pc_q;
        pc_out   = {bus_rdata, opnd_q};
        pc_we    = 1'b1;
        done     = 1'b1;
        state_d  = ST_IDLE;
      end
      ST_PUSH_B: begin
        bus_we    = 1'b1;
        bus_wdata = (seq_q == SQ_PUSH_ST) ? push_image(st_q) : acc_q;
        sp_op     = SP_DEC;
        done      = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_PULL_B: begin
        status_we = 1'b1;
        if (seq_q == SQ_PULL_ST) status_out = pull_merge(st_q, bus_rdata);
        else begin
          status_out = load_flags(st_q, bus_rdata);
          acc_out    = bus_rdata;
          acc_we     = 1'b1;
        end
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seq_q   <= SQ_SKIP;
      pc_q    <= '0;
      st_q    <= '0;
      acc_q   <= '0;
      opnd_q  <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        seq_q  <= seq_pick;
        pc_q   <= (seq_pick == SQ_BRK) ? pc_in + 1'b1 : pc_in;
        st_q   <= (seq_pick == SQ_BRK) ? push_image(status_in) : status_in;
        acc_q  <= acc_in;
        opnd_q <= req_opnd;
      end
      if (state_q == ST_VEC_L || state_q == ST_PULL_L) lo_q <= bus_rdata;
      if (state_q == ST_PULL_H) hi_q <= bus_rdata;
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk
  import ssq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] sp_out,
  input logic              status_we,
  input logic [DATA_W-1:0] status_out,
  input logic              entry_commit,
  input logic              vec_fetch,
  input logic              done,
  input logic [2:0]        done_kind,
  input logic              pc_we,
  input logic              xy_clr
);
  AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> sp_out == $past(sp_out) - 8'd1); // R1
  AST_PUSH_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_addr[15:8] == 8'h01); // R1
  AST_ENTRY_IDIS: assert property (@(posedge clk) disable iff (!rst_n)
    entry_commit |-> status_we && status_out[2] && pc_we && done); // R3
  AST_VEC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> !bus_we && bus_addr[15:8] == 8'hFF); // R4
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_kind == 3'd2 && !pc_we) |-> !bus_we && !status_we); // R5
  AST_RESET_SP: assert property (@(posedge clk) disable iff (!rst_n)
    xy_clr |=> sp_out == 8'hFF); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
endmodule

bind stack_seq stack_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .sp_out       (sp_out),
  .status_we    (status_we),
  .status_out   (status_out),
  .entry_commit (entry_commit),
  .vec_fetch    (vec_fetch),
  .done         (done),
  .done_kind    (done_kind),
  .pc_we        (pc_we),
  .xy_clr       (xy_clr)
);

// File: tb/test_stack_seq.sv
module test_stack_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, req_valid, nmi_pend, irq_pend;
  logic [2:0]  req_kind;
  logic [1:0]  req_stk;
  logic [7:0]  req_opnd;
  logic [15:0] bus_addr, pc_out;
  logic [7:0]  bus_wdata, bus_rdata, status_out, acc_out, sp_out;
  logic        bus_we, pc_we, status_we, acc_we, xy_clr, done;
  logic [2:0]  done_kind;

  logic [15:0] core_pc;
  logic [7:0]  core_st, core_a;
  logic [7:0]  stk [256];
  int          xy_pulses, bad_wr;
  int          n_chk, n_fail;
  logic [7:0]  m_sp;
  bit          summary_done;

  stack_seq i_stack_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_stk(req_stk), .req_opnd(req_opnd), .nmi_pend(nmi_pend), .irq_pend(irq_pend),
    .pc_in(core_pc), .status_in(core_st), .acc_in(core_a),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .pc_out(pc_out), .pc_we(pc_we), .status_out(status_out), .status_we(status_we),
    .acc_out(acc_out), .acc_we(acc_we), .xy_clr(xy_clr), .sp_out(sp_out),
    .done(done), .done_kind(done_kind)
  );

  function automatic logic [7:0] rom(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    return (a[15:8] == 8'h01) ? stk[a[7:0]] : rom(a);
  endfunction

  assign bus_rdata = mem_rd(bus_addr);

  // memory and core register file
  always @(posedge clk) begin
    if (bus_we) begin
      if (bus_addr[15:8] == 8'h01) stk[bus_addr[7:0]] <= bus_wdata;
      else bad_wr <= bad_wr + 1;
    end
    if (pc_we)     core_pc <= pc_out;
    if (status_we) core_st <= status_out;
    if (acc_we)    core_a  <= acc_out;
    if (xy_clr)    xy_pulses <= xy_pulses + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
  endtask

  // run one request, compute expectations from the requirements, compare
  task automatic do_seq(input logic [2:0] k, input logic [1:0] s, input logic [7:0] op,
                        input bit nmi, input bit irq);
    logic [15:0] pc0, e_pc, p, vec;
    logic [7:0]  st0, a0, sp0, e_st, e_a, e_sp, sv, lo, hi;
    logic [7:0]  pv [3];
    int          pn, e_len, len, eff, xy0;
    logic [2:0]  e_dk, dk;
    string       rq, spq;
    bit          fin;
    pc0 = core_pc; st0 = core_st; a0 = core_a; sp0 = m_sp;
    e_pc = pc0; e_st = st0; e_a = a0; e_sp = sp0; pn = 0; e_len = 1; spq = "R1";
    if (k == 3'd0) eff = 0;
    else if (nmi) eff = 1;
    else if (irq && !st0[2]) eff = 2;
    else if (k == 3'd2) eff = st0[2] ? 11 : 2;
    else if (k < 3'd7) eff = int'(k);
    else eff = 7 + int'(s);
    e_dk = (eff == 11) ? 3'd2 : (eff > 6) ? 3'd7 : 3'(eff);
    case (eff)
      0: begin
        rq = "R6"; e_a = 8'h00; e_st = 8'h00; e_sp = 8'hFF; e_len = 3;
        e_pc = {rom(16'hFFFD), rom(16'hFFFC)};
      end
      1, 2, 3: begin
        rq = (eff == 3) ? "R7" : "R3";
        p  = (eff == 3) ? pc0 + 16'd1 : pc0;
        sv = (eff == 3) ? (st0 | 8'h30) : st0;
        pv[0] = p[15:8]; pv[1] = p[7:0]; pv[2] = sv; pn = 3;
        vec = (eff == 1) ? 16'hFFFA : 16'hFFFE;
        e_pc = {rom(vec + 16'd1), rom(vec)};
        e_st = sv | 8'h04; e_sp = sp0 - 8'd3; e_len = 5;
      end
      4: begin
        rq = "R10"; pv[0] = pc0[15:8]; pv[1] = pc0[7:0]; pn = 2;
        e_pc = {mem_rd(pc0), op}; e_sp = sp0 - 8'd2; e_len = 4;
      end
      5: begin
        rq = "R11"; spq = "R2";
        lo = stk[8'(sp0 + 8'd1)]; hi = stk[8'(sp0 + 8'd2)];
        e_pc = {hi, lo} + 16'd1; e_sp = sp0 + 8'd2; e_len = 4;
      end
      6: begin
        rq = "R11"; spq = "R2";
        sv = stk[8'(sp0 + 8'd1)]; lo = stk[8'(sp0 + 8'd2)]; hi = stk[8'(sp0 + 8'd3)];
        e_st = (st0 & 8'h30) | (sv & 8'hCF); e_pc = {hi, lo};
        e_sp = sp0 + 8'd3; e_len = 4;
      end
      7: begin rq = "R8"; pv[0] = st0 | 8'h30; pn = 1; e_sp = sp0 - 8'd1; end
      8: begin rq = "R8"; pv[0] = a0; pn = 1; e_sp = sp0 - 8'd1; end
      9: begin
        rq = "R9"; spq = "R2"; sv = stk[8'(sp0 + 8'd1)];
        e_st = (st0 & 8'h30) | (sv & 8'hCF); e_sp = sp0 + 8'd1; e_len = 2;
      end
      10: begin
        rq = "R9"; spq = "R2"; e_a = stk[8'(sp0 + 8'd1)];
        e_st = (st0 & 8'h7D) | (e_a & 8'h80) | ((e_a == 8'h00) ? 8'h02 : 8'h00);
        e_sp = sp0 + 8'd1; e_len = 2;
      end
      default: rq = "R5";
    endcase
    xy0 = xy_pulses;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_stk = s; req_opnd = op;
    nmi_pend = nmi; irq_pend = irq;
    @(posedge clk);
    len = 0; fin = 1'b0; dk = 3'd0;
    while (!fin && len < 16) begin
      @(negedge clk);
      len++;
      if (done) begin
        fin = 1'b1; dk = done_kind;
      end else begin
        // R12: inputs scrambled while busy must be ignored
        req_kind = 3'($urandom); req_stk = 2'($urandom); req_opnd = 8'($urandom);
        nmi_pend = 1'($urandom); irq_pend = 1'($urandom);
      end
    end
    @(negedge clk);
    req_valid = 1'b0; nmi_pend = 1'b0; irq_pend = 1'b0;
    check(fin, "R12 done seen", int'(fin), 1);
    check(len == e_len, {rq, " cycle count"}, len, e_len);
    check(dk == e_dk, "R5/R12 done_kind", dk, e_dk);
    check(core_pc == e_pc, (eff <= 3) ? "R4 pc from vector" : {rq, " pc"}, core_pc, e_pc);
    check(core_st == e_st, {rq, " status"}, core_st, e_st);
    check(core_a == e_a, {rq, " accumulator"}, core_a, e_a);
    check(sp_out == e_sp, {spq, " stack pointer"}, sp_out, e_sp);
    for (int i = 0; i < pn; i++)
      check(stk[8'(sp0 - 8'(i))] == pv[i], "R1 pushed byte", stk[8'(sp0 - 8'(i))], pv[i]);
    check(xy_pulses - xy0 == ((eff == 0) ? 1 : 0), "R6 index clear pulse",
          xy_pulses - xy0, (eff == 0) ? 1 : 0);
    m_sp = e_sp;
  endtask

  task automatic set_core(input logic [15:0] pc, input logic [7:0] st, input logic [7:0] a);
    @(negedge clk);
    core_pc = (pc[15:8] == 8'h01) ? {8'h41, pc[7:0]} : pc;
    core_st = st; core_a = a;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    n_chk = 0; n_fail = 0; xy_pulses = 0; bad_wr = 0; summary_done = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_kind = 3'd0; req_stk = 2'd0; req_opnd = 8'd0;
    nmi_pend = 1'b0; irq_pend = 1'b0;
    core_pc = 16'h0000; core_st = 8'h00; core_a = 8'h00;
    for (int i = 0; i < 256; i++) stk[i] = 8'($urandom);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_sp = 8'hFF;
    @(negedge clk);
    check(done == 1'b0, "R12 idle after reset", done, 0);
    check(sp_out == 8'hFF, "R6 sp after reset", sp_out, 8'hFF);
    check(bus_we == 1'b0, "R1 no write when idle", bus_we, 0);

    // reset sequence
    set_core(16'h1234, 8'hFF, 8'h77);
    do_seq(3'd0, 2'd0, 8'h00, 1'b0, 1'b0);
    // push A, push status (0x30 forced), pull status (bits 4,5 kept), pull A
    set_core(core_pc, 8'h00, 8'h3C);
    do_seq(3'd7, 2'd1, 8'h00, 1'b0, 1'b0);
    do_seq(3'd7, 2'd0, 8'h00, 1'b0, 1'b0);
    set_core(core_pc, 8'hC3, core_a);
    do_seq(3'd7, 2'd2, 8'h00, 1'b0, 1'b0);
    do_seq(3'd7, 2'd3, 8'h00, 1'b0, 1'b0);
    // wrap: pull at FF reads 0x0100 and leaves 00, push at 00 leaves FF
    do_seq(3'd0, 2'd0, 8'h00, 1'b0, 1'b0);
    stk[0] = 8'h00;
    do_seq(3'd7, 2'd3, 8'h00, 1'b0, 1'b0);
    set_core(core_pc, core_st, 8'h9E);
    do_seq(3'd7, 2'd1, 8'h00, 1'b0, 1'b0);
    // NMI and IRQ together against a push request: NMI wins
    set_core(16'h8001, 8'h00, 8'h11);
    do_seq(3'd7, 2'd1, 8'h00, 1'b1, 1'b1);
    // requested IRQ with mask set: skip
    set_core(16'h8100, 8'h04, 8'h11);
    do_seq(3'd2, 2'd0, 8'h00, 1'b0, 1'b1);
    // pending IRQ with mask set does not preempt push status
    do_seq(3'd7, 2'd0, 8'h00, 1'b0, 1'b1);
    // pending IRQ with mask clear preempts break
    set_core(16'h9000, 8'h01, 8'h11);
    do_seq(3'd3, 2'd0, 8'h00, 1'b0, 1'b1);
    // break then interrupt return
    set_core(16'hC0FE, 8'h41, 8'h11);
    do_seq(3'd3, 2'd0, 8'h00, 1'b0, 1'b0);
    set_core(core_pc, 8'h00, core_a);
    do_seq(3'd6, 2'd0, 8'h00, 1'b0, 1'b0);
    // call then return: PC ends one past the pushed value
    set_core(16'h2002, 8'h00, 8'h00);
    do_seq(3'd4, 2'd0, 8'h34, 1'b0, 1'b0);
    do_seq(3'd5, 2'd0, 8'h00, 1'b0, 1'b0);
    check(core_pc == 16'h2003, "R11 return lands after call", core_pc, 16'h2003);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0] k;
      k = 3'($urandom_range(0, 7));
      if (k == 3'd0 && ($urandom % 4) != 0) k = 3'd7;
      set_core(16'($urandom), 8'($urandom), 8'($urandom));
      do_seq(k, 2'($urandom), 8'($urandom), ($urandom % 8) == 0, ($urandom % 5) == 0);
    end
    check(bad_wr == 0, "R1 writes outside page one", bad_wr, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end
endmodule